// File: doc/BRIEF.md
# Adaptive Noise Canceller with Serial LMS Filter

This block removes correlated noise from a speech channel. Two sample streams arrive under one strobe. The primary stream carries speech mixed with ambient noise. The reference stream carries the noise alone, picked up away from the talker. A transversal FIR filter runs over the recent reference history and forms an estimate of the noise that reached the primary input. The block subtracts that estimate from the primary sample to give the cleaned output. The same difference then drives a least-mean-squares correction of every filter weight.

One multiply-accumulate unit serves all taps. After a strobe is accepted, the block makes one pass over the taps to filter, takes one cycle to form the error, and makes a second pass to adapt the weights. It then raises a done strobe for one cycle. While a pass is running the block is busy, and any strobe that arrives is dropped. For a set number of samples after reset, the block learns the ambient noise: it adapts the weights normally but drives zero on the output. An external two-bit adjust input, taken with each sample, can bias the update so the weights shrink or grow slightly on top of the LMS step.

The controller has five named states:
- `ST_IDLE` waits for a strobe. IDLE→FILT happens on an accepted strobe.
- `ST_FILT` accumulates one tap per cycle. FILT→EST happens after the last tap.
- `ST_EST` rounds the sum, forms the error and registers the output. EST→UPD is unconditional.
- `ST_UPD` rewrites one weight per cycle. UPD→FIN happens after the last tap.
- `ST_FIN` raises the done strobe. FIN→IDLE is unconditional.

Top module: `lmsnc_top`

## Requirements
- R1: After reset, `busy`, `out_valid` and `out_sample` are all zero, every weight is zero and the reference history holds zeros.
- R2: A strobe seen on `in_valid` while `busy` is low is accepted. `busy` is high from the next cycle for exactly 2·TAPS+2 cycles.
- R3: A strobe that arrives while `busy` is high is dropped. It shifts no history, starts no pass and changes no later output.
- R4: `out_valid` is high for exactly one cycle, the last busy cycle of each pass. That is the (2·TAPS+2)-th cycle after the accepting edge.
- R5: At the accepting edge the new reference sample enters history slot 0 and every older slot moves up by one. The estimate is y = Σ w[i]·x[i], rounded by adding 2^(FRAC−1) and shifting right arithmetically by FRAC, then saturated to the signed SAMPLE_W range.
- R6: The error is e = primary − y, saturated to the signed SAMPLE_W range. This value appears on `out_sample` together with `out_valid`.
- R7: The first LEARN_SAMPLES accepted samples after reset give `out_sample` = 0, but their errors still adapt the weights.
- R8: Every pass filters with the weights left by the previous pass. It then sets each weight to w + ((e·x[i]) >>> MU_SHIFT), using arithmetic shifts.
- R9: `adj_mode` is taken at the accepting edge. Code 1 also subtracts (w >>> LEAK_SHIFT), code 2 also adds it, and codes 0 and 3 apply the plain update.
- R10: Each updated weight is saturated to the signed COEF_W range and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample strobe |
| prim_in | input | SAMPLE_W | Primary sample, speech plus noise, signed |
| ref_in | input | SAMPLE_W | Reference noise sample, signed |
| adj_mode | input | 2 | Update bias: 0/3 plain, 1 shrink, 2 grow |
| busy | output | 1 | A pass is in progress |
| out_valid | output | 1 | One-cycle done strobe |
| out_sample | output | SAMPLE_W | Cleaned sample, signed |

## Verification
The bench pokes `in_valid` in the middle of passes. A design that let such a strobe through would shift the history out of step, and every later output would differ. Other runs drive full-scale primary and reference values under the grow bias, which forces the error and the weights into saturation. A design that wrapped instead of clamping would jump sign at that point. The bench checks the boundary between the learning phase and normal output, where an off-by-one counter would show one wrongly muted or unmuted sample. It also steps through all four adjust codes, so a swapped shrink/grow decode changes the outputs. A second reset in the middle of the run confirms that the weights, history and learning count all start again.

// File: rtl/lmsnc_pkg.sv
package lmsnc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILT,
        ST_EST,
        ST_UPD,
        ST_FIN
    } lmsnc_state_t;

    typedef enum logic [1:0] {
        ADJ_PLAIN  = 2'd0,
        ADJ_SHRINK = 2'd1,
        ADJ_GROW   = 2'd2,
        ADJ_PLAIN2 = 2'd3
    } lmsnc_adj_t;

endpackage

// File: rtl/lmsnc_ref_hist.sv
module lmsnc_ref_hist #(
    parameter int TAPS     = 120,
    parameter int SAMPLE_W = 12,
    localparam int IW      = $clog2(TAPS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       shift_en,
    input  logic signed [SAMPLE_W-1:0] din,
    input  logic        [IW-1:0]       rd_idx,
    output logic signed [SAMPLE_W-1:0] rd_data
);

    logic signed [SAMPLE_W-1:0] hist_q [TAPS];

    // Slot 0 always holds the newest reference sample.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < TAPS; i++) hist_q[i] <= '0;
        end else if (shift_en) begin
            hist_q[0] <= din;
            for (int i = 1; i < TAPS; i++) hist_q[i] <= hist_q[i-1];
        end
    end

    assign rd_data = hist_q[rd_idx];

endmodule

// File: rtl/lmsnc_coef_bank.sv
module lmsnc_coef_bank #(
    parameter int TAPS   = 120,
    parameter int COEF_W = 16,
    localparam int IW    = $clog2(TAPS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic        [IW-1:0]     idx,
    output logic signed [COEF_W-1:0] rd_data,
    input  logic                     wr_en,
    input  logic signed [COEF_W-1:0] wr_data
);

    logic signed [COEF_W-1:0] coef_q [TAPS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < TAPS; i++) coef_q[i] <= '0;
        end else if (wr_en) begin
            coef_q[idx] <= wr_data;
        end
    end

    assign rd_data = coef_q[idx];

endmodule

// File: rtl/lmsnc_mac.sv
module lmsnc_mac #(
    parameter int SAMPLE_W = 12,
    parameter int COEF_W   = 16,
    parameter int ACC_W    = 37,
    parameter int FRAC     = 14
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       acc_en,
    input  logic signed [COEF_W-1:0]   w_in,
    input  logic signed [SAMPLE_W-1:0] x_in,
    output logic signed [SAMPLE_W-1:0] est_out
);

    localparam int PW = COEF_W + SAMPLE_W;
    localparam logic signed [ACC_W-1:0] RND_K = ACC_W'(1) <<< (FRAC - 1);
    localparam logic signed [ACC_W-1:0] Y_MAX = ACC_W'((1 << (SAMPLE_W - 1)) - 1);
    localparam logic signed [ACC_W-1:0] Y_MIN = ~Y_MAX;

    logic signed [PW-1:0]    prod;
    logic signed [ACC_W-1:0] acc_q;
    logic signed [ACC_W-1:0] rounded;
    logic signed [ACC_W-1:0] scaled;

    assign prod = w_in * x_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (clr) begin
            acc_q <= '0;
        end else if (acc_en) begin
            acc_q <= acc_q + ACC_W'(prod);
        end
    end

    // Round half up, then clamp to the sample range.
    always_comb begin
        rounded = acc_q + RND_K;
        scaled  = rounded >>> FRAC;
        if (scaled > Y_MAX)      est_out = Y_MAX[SAMPLE_W-1:0];
        else if (scaled < Y_MIN) est_out = Y_MIN[SAMPLE_W-1:0];
        else                     est_out = scaled[SAMPLE_W-1:0];
    end

endmodule

// File: rtl/lmsnc_update.sv
module lmsnc_update
    import lmsnc_pkg::*;
#(
    parameter int SAMPLE_W   = 12,
    parameter int COEF_W     = 16,
    parameter int MU_SHIFT   = 14,
    parameter int LEAK_SHIFT = 8
) (
    input  logic signed [COEF_W-1:0]   w_old,
    input  logic signed [SAMPLE_W-1:0] x_in,
    input  logic signed [SAMPLE_W-1:0] err,
    input  lmsnc_adj_t                 adj,
    output logic signed [COEF_W-1:0]   w_new
);

    localparam int PW   = 2 * SAMPLE_W;
    localparam int SUMW = ((PW > COEF_W) ? PW : COEF_W) + 2;
    localparam logic signed [SUMW-1:0] W_MAX = SUMW'((1 << (COEF_W - 1)) - 1);
    localparam logic signed [SUMW-1:0] W_MIN = ~W_MAX;

    logic signed [PW-1:0]     grad;
    logic signed [PW-1:0]     step;
    logic signed [COEF_W-1:0] leak;
    logic signed [SUMW-1:0]   sum;

    assign grad = err * x_in;
    assign step = grad >>> MU_SHIFT;
    assign leak = w_old >>> LEAK_SHIFT;

    always_comb begin
        unique case (adj)
            ADJ_SHRINK: sum = SUMW'(w_old) + SUMW'(step) - SUMW'(leak);
            ADJ_GROW:   sum = SUMW'(w_old) + SUMW'(step) + SUMW'(leak);
            default:    sum = SUMW'(w_old) + SUMW'(step);
        endcase
        if (sum > W_MAX)      w_new = W_MAX[COEF_W-1:0];
        else if (sum < W_MIN) w_new = W_MIN[COEF_W-1:0];
        else                  w_new = sum[COEF_W-1:0];
    end

endmodule

// File: rtl/lmsnc_top.sv
module lmsnc_top
    import lmsnc_pkg::*;
#(
    parameter int TAPS          = 120,
    parameter int SAMPLE_W      = 12,
    parameter int COEF_W        = 16,
    parameter int FRAC          = 14,
    parameter int MU_SHIFT      = 14,
    parameter int LEAK_SHIFT    = 8,
    parameter int LEARN_SAMPLES = 24000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] prim_in,
    input  logic [SAMPLE_W-1:0] ref_in,
    input  logic [1:0]          adj_mode,
    output logic                busy,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] out_sample
);

    localparam int IW    = $clog2(TAPS);
    localparam int LCW   = $clog2(LEARN_SAMPLES + 2);
    localparam int ACC_W = COEF_W + SAMPLE_W + $clog2(TAPS) + 2;
    localparam logic [IW-1:0] LAST_IDX = IW'(TAPS - 1);
    localparam logic signed [SAMPLE_W:0] E_MAX = (SAMPLE_W+1)'((1 << (SAMPLE_W - 1)) - 1);
    localparam logic signed [SAMPLE_W:0] E_MIN = ~E_MAX;

    lmsnc_state_t state_q, state_d;

    logic [IW-1:0]              idx_q;
    logic signed [SAMPLE_W-1:0] prim_q;
    lmsnc_adj_t                 adj_q;
    logic signed [SAMPLE_W-1:0] err_q;
    logic [SAMPLE_W-1:0]        out_q;
    logic [LCW-1:0]             learn_cnt_q;

    logic                       accept;
    logic                       last_tap;
    logic                       learning;
    logic signed [SAMPLE_W-1:0] x_rd;
    logic signed [COEF_W-1:0]   w_rd;
    logic signed [COEF_W-1:0]   w_upd;
    logic signed [SAMPLE_W-1:0] y_est;
    logic signed [SAMPLE_W:0]   diff;
    logic signed [SAMPLE_W-1:0] err_sat;

    assign accept   = (state_q == ST_IDLE) && in_valid;
    assign last_tap = (idx_q == LAST_IDX);
    assign learning = (learn_cnt_q < LCW'(LEARN_SAMPLES));

    // ---------------- submodules ----------------
    lmsnc_ref_hist #(
        .TAPS     (TAPS),
        .SAMPLE_W (SAMPLE_W)
    ) hist_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (accept),
        .din      ($signed(ref_in)),
        .rd_idx   (idx_q),
        .rd_data  (x_rd)
    );

    lmsnc_coef_bank #(
        .TAPS   (TAPS),
        .COEF_W (COEF_W)
    ) coef_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx     (idx_q),
        .rd_data (w_rd),
        .wr_en   (state_q == ST_UPD),
        .wr_data (w_upd)
    );

    lmsnc_mac #(
        .SAMPLE_W (SAMPLE_W),
        .COEF_W   (COEF_W),
        .ACC_W    (ACC_W),
        .FRAC     (FRAC)
    ) mac_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (accept),
        .acc_en  (state_q == ST_FILT),
        .w_in    (w_rd),
        .x_in    (x_rd),
        .est_out (y_est)
    );

    lmsnc_update #(
        .SAMPLE_W   (SAMPLE_W),
        .COEF_W     (COEF_W),
        .MU_SHIFT   (MU_SHIFT),
        .LEAK_SHIFT (LEAK_SHIFT)
    ) upd_i (
        .w_old (w_rd),
        .x_in  (x_rd),
        .err   (err_q),
        .adj   (adj_q),
        .w_new (w_upd)
    );

    // ---------------- error saturation ----------------
    always_comb begin
        diff = {prim_q[SAMPLE_W-1], prim_q} - {y_est[SAMPLE_W-1], y_est};
        if (diff > E_MAX)      err_sat = E_MAX[SAMPLE_W-1:0];
        else if (diff < E_MIN) err_sat = E_MIN[SAMPLE_W-1:0];
        else                   err_sat = diff[SAMPLE_W-1:0];
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid) state_d = ST_FILT;
            ST_FILT: if (last_tap) state_d = ST_EST;
            ST_EST:  state_d = ST_UPD;
            ST_UPD:  if (last_tap) state_d = ST_FIN;
            ST_FIN:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q       <= '0;
            prim_q      <= '0;
            adj_q       <= ADJ_PLAIN;
            err_q       <= '0;
            out_q       <= '0;
            learn_cnt_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    idx_q <= '0;
                    if (in_valid) begin
                        prim_q <= $signed(prim_in);
                        adj_q  <= lmsnc_adj_t'(adj_mode);
                    end
                end
                ST_FILT: idx_q <= last_tap ? '0 : idx_q + IW'(1);
                ST_EST: begin
                    idx_q <= '0;
                    err_q <= err_sat;
                    out_q <= learning ? '0 : err_sat;
                end
                ST_UPD:  idx_q <= last_tap ? '0 : idx_q + IW'(1);
                ST_FIN: begin
                    if (learning) learn_cnt_q <= learn_cnt_q + LCW'(1);
                end
                default: idx_q <= '0;
            endcase
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        busy       = (state_q != ST_IDLE);
        out_valid  = (state_q == ST_FIN);
        out_sample = out_q;
    end

    // ---------------- assertions ----------------
    a_r2_busy_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && in_valid) |=> busy);

    a_r3_pass_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !out_valid) |=> busy);

    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    a_r4_done_in_pass: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> busy);

    a_r6_stable_result: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $stable(out_sample));

    a_r7_muted: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && learning) |-> (out_sample == '0));

endmodule

// File: tb/lmsnc_top_tb_top.sv
`timescale 1ns/1ps
module lmsnc_top_tb_top;

    localparam int TAPS  = 120;
    localparam int SW    = 12;
    localparam int CW    = 16;
    localparam int FRAC  = 14;
    localparam int MU    = 8;
    localparam int LEAK  = 6;
    localparam int LEARN = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [SW-1:0] prim_in = '0;
    logic [SW-1:0] ref_in = '0;
    logic [1:0]    adj_mode = 2'd0;
    logic          busy;
    logic          out_valid;
    logic [SW-1:0] out_sample;

    always #4 clk = ~clk; // 125 MHz

    lmsnc_top #(
        .TAPS(TAPS), .SAMPLE_W(SW), .COEF_W(CW), .FRAC(FRAC),
        .MU_SHIFT(MU), .LEAK_SHIFT(LEAK), .LEARN_SAMPLES(LEARN)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .prim_in(prim_in), .ref_in(ref_in), .adj_mode(adj_mode),
        .busy(busy), .out_valid(out_valid), .out_sample(out_sample)
    );

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;
    string phase_tag = "R5 R8";

    // ---------------- behavioural reference model ----------------
    longint m_w [TAPS];
    longint m_x [TAPS];
    int     m_cnt = 0;
    int     m_done = 0;
    longint m_out = 0;
    bit     m_out_learn = 0;

    function automatic longint clampv(longint v, int bits);
        longint hi = (longint'(1) << (bits - 1)) - 1;
        longint lo = -hi - 1;
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    function automatic longint sx(logic [SW-1:0] v);
        return longint'($signed(v));
    endfunction

    task automatic model_step(longint p, longint r, int adj);
        longint acc, y, e, st, lk, nw;
        for (int i = TAPS - 1; i > 0; i--) m_x[i] = m_x[i-1];
        m_x[0] = r;
        acc = 0;
        for (int i = 0; i < TAPS; i++) acc += m_w[i] * m_x[i];
        y = clampv((acc + (longint'(1) << (FRAC - 1))) >>> FRAC, SW);
        e = clampv(p - y, SW);
        m_out_learn = (m_done < LEARN);
        m_out = m_out_learn ? 0 : e;
        m_done++;
        for (int i = 0; i < TAPS; i++) begin
            st = (e * m_x[i]) >>> MU;
            lk = m_w[i] >>> LEAK;
            nw = m_w[i] + st;
            if (adj == 1) nw -= lk;
            else if (adj == 2) nw += lk;
            m_w[i] = clampv(nw, CW);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0;
            m_done = 0;
            m_out = 0;
            for (int i = 0; i < TAPS; i++) begin m_w[i] = 0; m_x[i] = 0; end
        end else if (m_cnt == 0) begin
            if (in_valid) begin
                model_step(sx(prim_in), sx(ref_in), int'(adj_mode));
                m_cnt = 2 * TAPS + 2;
            end
        end else begin
            m_cnt--;
        end
    end

    // ---------------- per-clock comparison ----------------
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            compared++;
            if (busy !== (m_cnt != 0)) begin
                mismatched++;
                $display("FAIL R2 R3 busy: actual %0b expected %0b at %0t", busy, (m_cnt != 0), $time);
            end
            compared++;
            if (out_valid !== (m_cnt == 1)) begin
                mismatched++;
                $display("FAIL R4 out_valid: actual %0b expected %0b at %0t", out_valid, (m_cnt == 1), $time);
            end
            if (m_cnt == 1) begin
                compared++;
                if (sx(out_sample) != m_out) begin
                    mismatched++;
                    $display("FAIL %s %s out_sample: actual %0d expected %0d at %0t",
                             m_out_learn ? "R7" : "R6", phase_tag, sx(out_sample), m_out, $time);
                end
            end
        end
    end

    // ---------------- stimulus ----------------
    int unsigned lcg = 32'h1234_5678;

    function automatic int rnd_sample();
        lcg = lcg * 32'd1103515245 + 32'd12345;
        return int'((lcg >> 16) & 32'h7FF) - 1024;
    endfunction

    task automatic send(int p, int r, int adj, bit poke);
        do @(negedge clk); while (busy);
        in_valid = 1'b1;
        prim_in  = SW'(p);
        ref_in   = SW'(r);
        adj_mode = 2'(adj);
        @(negedge clk);
        in_valid = 1'b0;
        if (poke) begin
            // R3: strobe during a pass carries values that would change everything
            repeat (7) @(negedge clk);
            in_valid = 1'b1;
            prim_in  = SW'(-2048);
            ref_in   = SW'(2047);
            adj_mode = 2'd2;
            @(negedge clk);
            in_valid = 1'b0;
        end
        repeat (lcg[3:0] & 4'h3) @(negedge clk);
    endtask

    task automatic check_reset_state();
        compared++;
        if (busy !== 1'b0 || out_valid !== 1'b0 || out_sample !== '0) begin
            mismatched++;
            $display("FAIL R1 reset: actual busy=%0b valid=%0b sample=%0d expected 0 0 0",
                     busy, out_valid, sx(out_sample));
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check_reset_state();
        rst_n = 1'b1;
        @(negedge clk);
        check_reset_state();
    endtask

    initial begin
        int prev_r;
        prev_r = 0;
        do_reset();

        // R5 R6 R7 R8: correlated noise, crossing the learning boundary
        phase_tag = "R5 R8";
        for (int n = 0; n < 40; n++) begin
            int r = rnd_sample();
            send(((n % 16) - 8) * 40 + (prev_r * 3) / 4, r, 0, 0);
            prev_r = r;
        end
        // R9: each adjust code
        phase_tag = "R9 shrink";
        for (int n = 0; n < 15; n++) begin
            int r = rnd_sample();
            send((prev_r * 3) / 4 + 100, r, 1, 0);
            prev_r = r;
        end
        phase_tag = "R9 grow";
        for (int n = 0; n < 15; n++) begin
            int r = rnd_sample();
            send((prev_r * 3) / 4 - 100, r, 2, 0);
            prev_r = r;
        end
        phase_tag = "R9 code3";
        for (int n = 0; n < 10; n++) begin
            int r = rnd_sample();
            send(prev_r / 2, r, 3, 0);
            prev_r = r;
        end
        // R3: strobes during busy must be dropped
        phase_tag = "R3 poke";
        for (int n = 0; n < 12; n++) begin
            int r = rnd_sample();
            send((prev_r * 3) / 4, r, 0, 1);
            prev_r = r;
        end

        // R1 again, then R10 and R6 saturation at full scale
        do_reset();
        phase_tag = "R10 sat";
        for (int n = 0; n < 40; n++) begin
            send((n % 2 == 0) ? -2048 : 2047, (n < 25) ? 2047 : -2048, 2, 0);
        end
        phase_tag = "R10 R6 sat";
        for (int n = 0; n < 20; n++) begin
            send(2047, (n % 3 == 0) ? -2048 : 2047, 0, 0);
        end

        do @(negedge clk); while (busy);
        repeat (4) @(negedge clk);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            mismatched++;
            $display("FAIL watchdog: actual hung run expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule